// File: doc/BRIEF.md
# Per-Lane Sampling Tap Trainer

This block picks, separately for each IO lane of a source-synchronous serial memory read port, which of several pre-delayed sample streams should capture the read data. Each lane delivers four sample streams, taps 0 to 3, where tap 0 is the least delayed (suited to a fast-process device) and tap 3 the most delayed (suited to a slow-process device). The delay line is outside the block. Its outputs arrive here as one bit per tap per lane, and each bit is already registered once per sample slot, which is one clock cycle.

A read command opens a learning window whose length is the programmed latency. During the last eight slots of that window the memory drives a known 8-bit pattern on every lane. The block compares every tap of every lane against the programmed pattern. When the pattern ends it settles on one tap per lane, holds that choice for the whole data phase, and forwards the bits sampled on the chosen taps. Those bits go on to a separate clock-crossing FIFO. Every new read command trains the taps again.

The controller has four states. `ST_IDLE` waits for a read. It moves to `ST_WAIT` on a read start when the effective latency is more than 8, and to `ST_LEARN` directly otherwise. `ST_WAIT` counts the slots that come before the pattern and moves to `ST_LEARN` on the slot just before the pattern. `ST_LEARN` compares eight pattern bits and moves to `ST_DATA` after the last of them. `ST_DATA` forwards data and moves back to `ST_IDLE` on a read stop.

Top module: `lane_tap_trainer`

## Requirements
- R1: After reset, `data_valid` is 0, `train_err` is 0, `data_out` is 0 and every lane's selected tap in `sel_taps` is 0.
- R2: A `rd_start` pulse in idle opens a learning window of L slots, with the first slot in the cycle after the pulse. L is `latency`, or 8 when `latency` is below 8. The pattern occupies slots L-8 to L-1, most significant bit first, so slot L-8 carries `pattern[7]`. `data_valid` stays 0 throughout the window and is 1 from slot L onward.
- R3: A tap passes only if all eight of its samples in the pattern slots equal the corresponding pattern bits. A single mismatching bit fails the tap. Each lane is judged on its own taps only: lane l, tap t is `tap_bits[l*4+t]`.
- R4: Of the passing taps on a lane, the block takes the earliest contiguous run of passing taps and chooses its middle tap. When the run has an even length it rounds toward the earlier tap. The choice for lane l is published in `sel_taps[l*2 +: 2]` from slot L onward.
- R5: A lane with no passing tap uses `dflt_tap`, and `train_err` is set to 1. `train_err` stays at 1 until reset, including through later error-free reads.
- R6: During the data phase, `data_out[l]` equals `tap_bits[l*4 + sel]`, where sel is lane l's chosen tap. The choice does not change during the data phase, and a `rd_start` pulse there is ignored.
- R7: `rd_stop` during the data phase ends the read. `data_valid` is 0 in the following cycle, and `data_out` is 0 whenever `data_valid` is 0.
- R8: Every read trains again from scratch, so a lane's choice follows the current read's comparison results and not those of earlier reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample-slot clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_start | input | 1 | Read command issued (pulse) |
| rd_stop | input | 1 | End of read data phase (pulse) |
| pattern | input | 8 | Expected learning pattern, most significant bit first |
| latency | input | 6 | Learning window length in slots |
| dflt_tap | input | 2 | Fallback tap for a lane with no passing tap |
| tap_bits | input | 32 | Per-lane, per-tap sampled bits, lane l tap t at bit l*4+t |
| data_out | output | 8 | Data bit of each lane taken from its chosen tap |
| data_valid | output | 1 | High during the data phase |
| sel_taps | output | 16 | Chosen tap of each lane, 2 bits per lane |
| train_err | output | 1 | Sticky flag: some lane had no passing tap |

## Verification
A sweep applies to every lane, across sixteen reads, all sixteen pass/fail combinations of its four taps. A failing tap is produced by corrupting one pattern bit at a position that moves from read to read. Along the way the sweep covers the empty set, single passing taps, runs of even and odd length, and split runs, which show whether the earliest run and rounding toward the earlier tap are honoured. The latency cycles through a value below 8, exactly 8 and two longer values, which separates the clamped window from the counted wait. The pattern and fallback tap change on every read, and the tap data in the data phase differs from tap to tap, so a wrong selection or a stale selection from the previous read shows up directly in `data_out`.

// File: rtl/lane_tap_trainer_pkg.sv
package lane_tap_trainer_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WAIT  = 2'd1,
        ST_LEARN = 2'd2,
        ST_DATA  = 2'd3
    } trn_state_t;

endpackage

// File: rtl/ltt_lane_cmp.sv
module ltt_lane_cmp #(
    parameter int TAPS = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clear,
    input  logic            cmp_en,
    input  logic            exp_bit,
    input  logic [TAPS-1:0] taps,
    output logic [TAPS-1:0] pass_q,
    output logic [TAPS-1:0] pass_nxt
);

    logic [TAPS-1:0] hit;

    always_comb begin
        hit      = ~(taps ^ {TAPS{exp_bit}});
        pass_nxt = cmp_en ? (pass_q & hit) : pass_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pass_q <= '0;
        end else if (clear) begin
            pass_q <= '1;
        end else begin
            pass_q <= pass_nxt;
        end
    end

    AST_PASS_ONLY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        !clear |=> ((pass_q & ~$past(pass_q)) == '0)); // R3

endmodule

// File: rtl/ltt_tap_pick.sv
module ltt_tap_pick #(
    parameter int TAPS   = 4,
    parameter int TSEL_W = $clog2(TAPS)
) (
    input  logic [TAPS-1:0]   pass,
    input  logic [TSEL_W-1:0] dflt,
    output logic [TSEL_W-1:0] sel,
    output logic              none
);

    int   lo;
    int   hi;
    logic found;
    logic run;

    always_comb begin
        found = 1'b0;
        lo    = 0;
        run   = 1'b1;
        for (int t = 0; t < TAPS; t++) begin
            if (!found && pass[t]) begin
                found = 1'b1;
                lo    = t;
            end
        end
        hi = lo;
        for (int t = 0; t < TAPS; t++) begin
            if (t > lo) begin
                if (run && pass[t]) begin
                    hi = t;
                end else begin
                    run = 1'b0;
                end
            end
        end
        none = !found;
        sel  = found ? TSEL_W'((lo + hi) / 2) : dflt;
    end

    always_comb begin
        if (pass != '0) begin
            AST_PICK_PASSES: assert (pass[sel]); // R4
        end else begin
            AST_PICK_DEFAULT: assert (sel == dflt); // R5
        end
    end

endmodule

// File: rtl/ltt_lane_mux.sv
module ltt_lane_mux #(
    parameter int TAPS   = 4,
    parameter int TSEL_W = $clog2(TAPS)
) (
    input  logic [TAPS-1:0]   taps,
    input  logic [TSEL_W-1:0] sel,
    input  logic              en,
    output logic              dout
);

    always_comb begin
        dout = en ? taps[sel] : 1'b0;
    end

endmodule

// File: rtl/lane_tap_trainer.sv
module lane_tap_trainer
    import lane_tap_trainer_pkg::*;
#(
    parameter int LANES = 8,
    parameter int TAPS  = 4,
    parameter int PAT_W = 8,
    parameter int LAT_W = 6
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            rd_start,
    input  logic                            rd_stop,
    input  logic [PAT_W-1:0]                pattern,
    input  logic [LAT_W-1:0]                latency,
    input  logic [$clog2(TAPS)-1:0]         dflt_tap,
    input  logic [LANES*TAPS-1:0]           tap_bits,
    output logic [LANES-1:0]                data_out,
    output logic                            data_valid,
    output logic [LANES*$clog2(TAPS)-1:0]   sel_taps,
    output logic                            train_err
);

    localparam int TSEL_W = $clog2(TAPS);
    localparam int BIT_W  = $clog2(PAT_W);

    trn_state_t        state_q;
    trn_state_t        state_d;
    logic [LAT_W-1:0]  cnt_q;
    logic [BIT_W-1:0]  bidx_q;
    logic [LAT_W-1:0]  eff_lat;
    logic [LAT_W-1:0]  wait_last;

    logic clear;
    logic cmp_en;
    logic learn_last;
    logic exp_bit;

    logic [LANES-1:0]  lane_none;
    logic [TSEL_W-1:0] sel_q   [LANES];
    logic [TSEL_W-1:0] pick_sel[LANES];

    always_comb begin
        eff_lat   = (latency < LAT_W'(PAT_W)) ? LAT_W'(PAT_W) : latency;
        wait_last = eff_lat - LAT_W'(PAT_W + 1);
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (rd_start) state_d = (eff_lat > LAT_W'(PAT_W)) ? ST_WAIT : ST_LEARN;
            ST_WAIT:  if (cnt_q == wait_last) state_d = ST_LEARN;
            ST_LEARN: if (bidx_q == '0) state_d = ST_DATA;
            ST_DATA:  if (rd_stop) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // outputs decoded from state
    always_comb begin
        clear      = (state_q == ST_IDLE) && rd_start;
        cmp_en     = (state_q == ST_LEARN);
        learn_last = (state_q == ST_LEARN) && (bidx_q == '0);
        data_valid = (state_q == ST_DATA);
        exp_bit    = pattern[bidx_q];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            bidx_q <= BIT_W'(PAT_W - 1);
        end else begin
            if (clear) begin
                cnt_q <= '0;
            end else if (state_q == ST_WAIT) begin
                cnt_q <= cnt_q + 1'b1;
            end
            if (state_q == ST_LEARN) begin
                bidx_q <= bidx_q - 1'b1;
            end else begin
                bidx_q <= BIT_W'(PAT_W - 1);
            end
        end
    end

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [TAPS-1:0] pass_q;
        logic [TAPS-1:0] pass_nxt;

        ltt_lane_cmp #(.TAPS(TAPS)) u_cmp (
            .clk      (clk),
            .rst_n    (rst_n),
            .clear    (clear),
            .cmp_en   (cmp_en),
            .exp_bit  (exp_bit),
            .taps     (tap_bits[l*TAPS +: TAPS]),
            .pass_q   (pass_q),
            .pass_nxt (pass_nxt)
        );

        ltt_tap_pick #(.TAPS(TAPS), .TSEL_W(TSEL_W)) u_pick (
            .pass (pass_nxt),
            .dflt (dflt_tap),
            .sel  (pick_sel[l]),
            .none (lane_none[l])
        );

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sel_q[l] <= '0;
            end else if (learn_last) begin
                sel_q[l] <= pick_sel[l];
            end
        end

        ltt_lane_mux #(.TAPS(TAPS), .TSEL_W(TSEL_W)) u_mux (
            .taps (tap_bits[l*TAPS +: TAPS]),
            .sel  (sel_q[l]),
            .en   (data_valid),
            .dout (data_out[l])
        );

        assign sel_taps[l*TSEL_W +: TSEL_W] = sel_q[l];

        AST_SEL_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
            (state_q == ST_DATA && $past(state_q) == ST_DATA) |-> $stable(sel_q[l])); // R6
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            train_err <= 1'b0;
        end else if (learn_last && (lane_none != '0)) begin
            train_err <= 1'b1;
        end
    end

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        $past(train_err) |-> train_err); // R5

    AST_VALID_AFTER_PATTERN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(data_valid) |-> $past(learn_last)); // R2

    AST_STOP_ENDS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (data_valid && rd_stop) |=> !data_valid); // R7

    AST_OUT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !data_valid |-> (data_out == '0)); // R7

endmodule

// File: tb/lane_tap_trainer_bench.sv
module lane_tap_trainer_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rd_start = 1'b0;
    logic        rd_stop = 1'b0;
    logic [7:0]  pattern = 8'h00;
    logic [5:0]  latency = 6'd8;
    logic [1:0]  dflt_tap = 2'd0;
    logic [31:0] tap_bits = '0;
    logic [7:0]  data_out;
    logic        data_valid;
    logic [15:0] sel_taps;
    logic        train_err;

    int n_chk = 0;
    int n_bad = 0;
    bit err_seen = 1'b0;

    always #10 clk = ~clk;

    lane_tap_trainer u_lane_tap_trainer (
        .clk(clk), .rst_n(rst_n), .rd_start(rd_start), .rd_stop(rd_stop),
        .pattern(pattern), .latency(latency), .dflt_tap(dflt_tap),
        .tap_bits(tap_bits), .data_out(data_out), .data_valid(data_valid),
        .sel_taps(sel_taps), .train_err(train_err)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int exp_pick(input int m, input int d);
        int lo = -1;
        int hi;
        for (int t = 0; t < 4; t++) if (lo < 0 && m[t]) lo = t;
        if (lo < 0) return d;
        hi = lo;
        while (hi + 1 < 4 && m[hi + 1]) hi++;
        return (lo + hi) / 2;
    endfunction

    function automatic bit data_bit(input int l, input int t, input int d, input int it);
        return 1'(((l * 3 + t * 5 + d * 7 + it * 11) % 13) & 1);
    endfunction

    task automatic do_read(input int it, input int lat, input logic [7:0] pat,
                           input int dflt, input int m0, input int m1, input int m2,
                           input int m3, input int m4, input int m5, input int m6,
                           input int m7);
        int masks[8];
        int eff;
        int esel[8];
        logic [7:0] expd;
        bit any_zero;
        masks = '{m0, m1, m2, m3, m4, m5, m6, m7};
        eff = (lat < 8) ? 8 : lat;
        any_zero = 1'b0;
        for (int l = 0; l < 8; l++) begin
            esel[l] = exp_pick(masks[l], dflt);
            if (masks[l] == 0) any_zero = 1'b1;
        end
        @(negedge clk);
        pattern  = pat;
        latency  = 6'(lat);
        dflt_tap = 2'(dflt);
        rd_start = 1'b1;
        for (int s = 0; s < eff; s++) begin
            @(negedge clk);
            rd_start = 1'b0;
            for (int l = 0; l < 8; l++) begin
                for (int t = 0; t < 4; t++) begin
                    if (s < eff - 8) begin
                        tap_bits[l*4+t] = 1'((s + l + t) & 1);
                    end else begin
                        int k = s - (eff - 8);
                        bit b = pat[7 - k];
                        bit bad = !masks[l][t] && (k == ((l + t + it) % 8));
                        tap_bits[l*4+t] = b ^ bad;
                    end
                end
            end
            #1;
            if (s == eff - 1) check("R2 valid low in window", int'(data_valid), 0);
        end
        for (int d = 0; d < 3; d++) begin
            @(negedge clk);
            rd_start = (d == 1);
            expd = '0;
            for (int l = 0; l < 8; l++) begin
                for (int t = 0; t < 4; t++) tap_bits[l*4+t] = data_bit(l, t, d, it);
                expd[l] = data_bit(l, esel[l], d, it);
            end
            #1;
            check("R2 valid in data phase", int'(data_valid), 1);
            check("R6 data from chosen taps", int'(data_out), int'(expd));
            if (d == 0) begin
                for (int l = 0; l < 8; l++)
                    check($sformatf("R4 R8 lane %0d mask %0d pick", l, masks[l]),
                          int'(sel_taps[l*2 +: 2]), esel[l]);
                if (any_zero) err_seen = 1'b1;
                check("R5 sticky error flag", int'(train_err), int'(err_seen));
            end
            if (d == 2) begin
                for (int l = 0; l < 8; l++)
                    check("R6 choice frozen, rd_start ignored", int'(sel_taps[l*2 +: 2]), esel[l]);
            end
        end
        @(negedge clk);
        rd_start = 1'b0;
        rd_stop  = 1'b1;
        @(negedge clk);
        rd_stop  = 1'b0;
        #1;
        check("R7 valid drops after stop", int'(data_valid), 0);
        check("R7 data quiet when idle", int'(data_out), 0);
    endtask

    initial begin
        #(20 * 20000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        check("R1 reset valid", int'(data_valid), 0);
        check("R1 reset err", int'(train_err), 0);
        check("R1 reset sel", int'(sel_taps), 0);
        check("R1 reset data", int'(data_out), 0);
        @(negedge clk);
        rst_n = 1'b1;
        // all taps pass: middle of 0..3 rounds to 1, no error (R3 R4 R5)
        do_read(0, 8, 8'hC3, 3, 15, 15, 15, 15, 15, 15, 15, 15);
        for (int it = 0; it < 16; it++) begin
            int lats[4] = '{3, 8, 9, 13};
            int m[8];
            for (int l = 0; l < 8; l++) m[l] = (it + l * 5) % 16;
            do_read(it, lats[it % 4], 8'(8'hA5 ^ (it * 37)), it % 4,
                    m[0], m[1], m[2], m[3], m[4], m[5], m[6], m[7]);
        end
        // an error-free read after errors keeps the flag set (R5)
        do_read(3, 10, 8'h5A, 2, 15, 14, 7, 6, 1, 8, 12, 3);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule